// File: doc/BRIEF.md
# BCH Syndrome Generator Using Minimal-Polynomial Remainders

This block computes the 2t syndromes of a received binary BCH word. The word arrives P bits per clock. For every odd syndrome index i, a small divider keeps the remainder of the received polynomial modulo the minimal polynomial of alpha^i. That remainder is only M bits wide. When the last word of a frame arrives, each remainder is evaluated at alpha^i with fixed GF(2^M) constant sums. Each even-index syndrome is the square of the syndrome at half its index. All odd-index dividers run side by side and do not depend on one another.

The syndrome vector and an error flag are registered. They are presented together with a one-cycle done strobe. A downstream key-equation solver starts only when the error flag is high, which means at least one syndrome is nonzero. By default the block handles the BCH(15,7,2) code over GF(2^4) with primitive polynomial x^4+x+1, and it accepts 4 bits per clock.

A small control machine has three states:
- ST_IDLE waits for a frame.
- ST_COLLECT takes words until the frame's word count is reached.
- ST_REPORT lasts one cycle and drives done.

The transitions are:
- ST_IDLE to ST_COLLECT on a start word.
- ST_IDLE to ST_REPORT on a start word when a frame is a single word.
- ST_COLLECT to ST_REPORT on the last word.
- ST_COLLECT to itself on stalls and on middle words.
- ST_REPORT to ST_IDLE when no start word is present.
- ST_REPORT to ST_COLLECT or ST_REPORT when a new frame starts at once.

Top module: `bch_syndrome_gen`

## Requirements
- R1: While reset is asserted and after it is released, done and err_detected are 0 and syndromes is all zero until the first frame completes.
- R2: A frame is WORDS = ceil(N/P) accepted words. The first bit received is the coefficient of x^(N-1). Within a word, bit P-1 is received first. Any padding bits are the top bits of the first word and must be zero.
- R3: Cycles with data_valid low inside a frame are stalls. They do not change the result.
- R4: done goes high in the cycle after the last word is accepted, and stays high for one cycle only.
- R5: For odd i, field S_i equals r(alpha^i). Field elements use bit k as the coefficient of alpha^k, over the primitive polynomial PRIM (default x^4+x+1). S_i occupies syndromes[(i-1)*M +: M].
- R6: For even i, S_i equals S_(i/2) squared in GF(2^M).
- R7: A valid codeword gives all-zero syndromes and err_detected = 0.
- R8: err_detected is 1 exactly when some syndrome is nonzero. It is updated with the syndromes at done and holds until the next frame completes.
- R9: A word with frame_start and data_valid both high always begins a new frame. This applies even in the middle of a frame, and it discards the earlier partial frame.
- R10: In ST_IDLE, a word with data_valid high and frame_start low is ignored. No done is produced and the outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Marks the first word of a frame |
| data_valid | input | 1 | Qualifies data_word |
| data_word | input | P | Received bits, MSB first |
| syndromes | output | 2*T*M | S_1..S_2T, with S_i at [(i-1)*M +: M] |
| done | output | 1 | One-cycle strobe when the syndromes are ready |
| err_detected | output | 1 | Some syndrome is nonzero |

## Verification
The bench builds the block with its defaults: M=4, T=2, N=15 and P=4. With these values a frame is four words with one zero pad bit. Codewords and error patterns up to the full 15 bits are therefore cheap to enumerate. The expected syndromes are computed by evaluating the received word directly at alpha^i. That is a different route from the block's remainder-then-evaluate path, so a mistake in a divider tap, in a constant sum or in the squaring shows up as a mismatch. The small frame length also puts stalls, mid-frame restarts and ignored idle words within easy reach.

// File: rtl/bch_syn_pkg.sv
package bch_syn_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_REPORT  = 2'd2
    } syn_state_t;
endpackage

// File: rtl/bch_rem_lfsr.sv
module bch_rem_lfsr #(
    parameter int         M   = 4,
    parameter int         P   = 4,
    parameter logic [M:0] PHI = 5'b10011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic         restart,
    input  logic [P-1:0] data_word,
    output logic [M-1:0] rem_q,
    output logic [M-1:0] rem_next
);
    // divide by PHI: each bit does r = r*x + b mod PHI
    always_comb begin
        logic [M-1:0] acc;
        logic         fb;
        acc = restart ? '0 : rem_q;
        for (int b = P - 1; b >= 0; b--) begin
            fb  = acc[M-1];
            acc = {acc[M-2:0], data_word[b]};
            if (fb) acc = acc ^ PHI[M-1:0];
        end
        rem_next = acc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       rem_q <= '0;
        else if (load_en) rem_q <= rem_next;
    end
endmodule

// File: rtl/bch_syn_eval.sv
module bch_syn_eval #(
    parameter int         M    = 4,
    parameter int         T    = 2,
    parameter logic [M:0] PRIM = 5'b10011
) (
    input  logic [T*M-1:0]   rem_flat,
    output logic [2*T*M-1:0] syn_flat
);
    localparam int Q = (1 << M) - 1;

    function automatic logic [M-1:0] times_x(input logic [M-1:0] a);
        logic [M-1:0] r;
        r = {a[M-2:0], 1'b0};
        if (a[M-1]) r = r ^ PRIM[M-1:0];
        return r;
    endfunction

    function automatic logic [M-1:0] alpha_pow(input int k);
        logic [M-1:0] r;
        r    = '0;
        r[0] = 1'b1;
        for (int n = 0; n < Q; n++)
            if (n < k) r = times_x(r);
        return r;
    endfunction

    function automatic logic [M-1:0] gf_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] acc;
        logic [M-1:0] sh;
        acc = '0;
        sh  = a;
        for (int k = 0; k < M; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = times_x(sh);
        end
        return acc;
    endfunction

    always_comb begin
        logic [M-1:0] s [2*T+1];
        logic [M-1:0] rem;
        s[0] = '0;
        for (int idx = 1; idx <= 2 * T; idx++) begin
            if (idx % 2 == 1) begin
                rem = rem_flat[((idx - 1) / 2) * M +: M];
                s[idx] = '0;
                for (int j = 0; j < M; j++)
                    if (rem[j]) s[idx] = s[idx] ^ alpha_pow((idx * j) % Q);
            end else begin
                s[idx] = gf_mul(s[idx / 2], s[idx / 2]);
            end
        end
        for (int idx = 1; idx <= 2 * T; idx++)
            syn_flat[(idx - 1) * M +: M] = s[idx];
    end
endmodule

// File: rtl/bch_syn_ctrl.sv
module bch_syn_ctrl
    import bch_syn_pkg::*;
#(
    parameter int WORDS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic data_valid,
    output logic accept,
    output logic restart,
    output logic last_word,
    output logic done
);
    localparam int CW = $clog2(WORDS + 1);

    syn_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= CW'(1);
        else if (accept)  cnt_q <= cnt_q + CW'(1);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (last_word)   state_d = ST_REPORT;
                else if (accept) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (last_word)   state_d = ST_REPORT;
            end
            ST_REPORT: begin
                if (last_word)   state_d = ST_REPORT;
                else if (accept) state_d = ST_COLLECT;
                else             state_d = ST_IDLE;
            end
            default:             state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        restart   = data_valid & frame_start;
        accept    = data_valid & (frame_start | (state_q == ST_COLLECT));
        last_word = accept & (restart ? (WORDS == 1) : (cnt_q == CW'(WORDS - 1)));
        done      = (state_q == ST_REPORT);
    end
endmodule

// File: rtl/bch_syndrome_gen.sv
module bch_syndrome_gen #(
    parameter int                 M         = 4,
    parameter int                 T         = 2,
    parameter int                 N         = 15,
    parameter int                 P         = 4,
    parameter logic [M:0]         PRIM      = 5'b10011,
    parameter logic [T*(M+1)-1:0] MIN_POLYS = {5'b11111, 5'b10011}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             data_valid,
    input  logic [P-1:0]     data_word,
    output logic [2*T*M-1:0] syndromes,
    output logic             done,
    output logic             err_detected
);
    localparam int WORDS = (N + P - 1) / P;

    logic             accept, restart, last_word;
    logic [T*M-1:0]   rem_q_flat, rem_next_flat;
    logic [2*T*M-1:0] syn_next;
    logic [2*T*M-1:0] syn_q;
    logic             err_q;

    bch_syn_ctrl #(.WORDS(WORDS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .data_valid (data_valid),
        .accept     (accept),
        .restart    (restart),
        .last_word  (last_word),
        .done       (done)
    );

    for (genvar k = 0; k < T; k++) begin : g_div
        bch_rem_lfsr #(
            .M  (M),
            .P  (P),
            .PHI(MIN_POLYS[k*(M+1) +: M+1])
        ) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (accept),
            .restart  (restart),
            .data_word(data_word),
            .rem_q    (rem_q_flat[k*M +: M]),
            .rem_next (rem_next_flat[k*M +: M])
        );
    end

    bch_syn_eval #(.M(M), .T(T), .PRIM(PRIM)) u_eval (
        .rem_flat(rem_next_flat),
        .syn_flat(syn_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syn_q <= '0;
            err_q <= 1'b0;
        end else if (last_word) begin
            syn_q <= syn_next;
            err_q <= |syn_next;
        end
    end

    assign syndromes    = syn_q;
    assign err_detected = err_q;
endmodule

// File: rtl/bch_syndrome_gen_chk.sv
module bch_syndrome_gen_chk #(
    parameter int SW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          data_valid,
    input logic          done,
    input logic          err_detected,
    input logic [SW-1:0] syndromes
);
    // R8
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (syndromes == '0) |-> !err_detected);

    // R8
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_detected |-> (syndromes != '0));

    // R8
    syn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(syndromes) |-> done);

    // R4
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(data_valid));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && !err_detected));
endmodule

bind bch_syndrome_gen bch_syndrome_gen_chk #(.SW(2*T*M)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_valid  (data_valid),
    .done        (done),
    .err_detected(err_detected),
    .syndromes   (syndromes)
);

// File: tb/bch_syndrome_gen_bench.sv
module bch_syndrome_gen_bench;
    localparam int M = 4, T = 2, N = 15, P = 4;
    localparam int WORDS = (N + P - 1) / P;
    localparam int PADW  = WORDS * P;
    localparam logic [8:0] GEN = 9'b111010001; // x^8+x^7+x^6+x^4+1

    // {message[6:0], error[14:0]}
    localparam logic [21:0] VEC [8] = '{
        {7'h00, 15'h0000}, {7'h5A, 15'h0000}, {7'h7F, 15'h0000}, {7'h13, 15'h0001},
        {7'h21, 15'h4000}, {7'h66, 15'h0410}, {7'h0F, 15'h2208}, {7'h3C, 15'h7FFF}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_start = 1'b0;
    logic             data_valid = 1'b0;
    logic [P-1:0]     data_word = '0;
    logic [2*T*M-1:0] syndromes;
    logic             done;
    logic             err_detected;

    int tests = 0;
    int fails = 0;
    logic [M-1:0] ap [15];

    always #4 clk = ~clk;

    bch_syndrome_gen u_bch_syndrome_gen (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .data_valid(data_valid),
        .data_word(data_word), .syndromes(syndromes), .done(done), .err_detected(err_detected)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [14:0] encode(input logic [6:0] msg);
        logic [14:0] r;
        r = {msg, 8'h00};
        for (int k = 14; k >= 8; k--)
            if (r[k]) r = r ^ (15'(GEN) << (k - 8));
        return {msg, r[7:0]};
    endfunction

    function automatic logic [M-1:0] mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] acc, sh;
        acc = '0; sh = a;
        for (int k = 0; k < M; k++) begin
            if (b[k]) acc ^= sh;
            sh = {sh[M-2:0], 1'b0} ^ (sh[M-1] ? 4'b0011 : 4'b0000);
        end
        return acc;
    endfunction

    // direct evaluation r(alpha^i); returns S4..S1 packed
    function automatic logic [15:0] expect_syn(input logic [14:0] r);
        logic [15:0] s;
        s = '0;
        for (int i = 1; i <= 2 * T; i++)
            for (int j = 0; j < N; j++)
                if (r[j]) s[(i - 1) * M +: M] ^= ap[(i * j) % 15];
        return s;
    endfunction

    task automatic send_frame(input logic [14:0] r, input bit gaps);
        logic [PADW-1:0] pw;
        pw = PADW'(r);
        for (int w = 0; w < WORDS; w++) begin
            @(negedge clk);
            data_valid  = 1'b1;
            frame_start = (w == 0);
            data_word   = pw[(WORDS - 1 - w) * P +: P];
            @(posedge clk);
            if (gaps && w < WORDS - 1) begin
                @(negedge clk);
                data_valid = 1'b0; frame_start = 1'b0; data_word = 4'hF;
                @(posedge clk);
            end
        end
        @(negedge clk);
        data_valid = 1'b0; frame_start = 1'b0; data_word = '0;
    endtask

    task automatic finish_report();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_report();
    end

    initial begin
        logic [14:0] word;
        logic [15:0] exp;
        logic [15:0] held;
        ap[0] = 4'b0001;
        for (int k = 1; k < 15; k++)
            ap[k] = {ap[k-1][2:0], 1'b0} ^ (ap[k-1][3] ? 4'b0011 : 4'b0000);

        repeat (3) @(negedge clk);
        chk("R1 done in reset", 32'(done), 0);
        chk("R1 err in reset", 32'(err_detected), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 syndromes after reset", 32'(syndromes), 0);
        chk("R1 done after reset", 32'(done), 0);

        for (int v = 0; v < 8; v++) begin
            word = encode(VEC[v][21:15]) ^ VEC[v][14:0];
            exp  = expect_syn(word);
            send_frame(word, 1'b0);
            chk("R4 done strobe", 32'(done), 1);
            chk("R5 R6 syndromes vs r(alpha^i)", 32'(syndromes), 32'(exp));
            chk("R8 err flag", 32'(err_detected), 32'(exp != 0));
            chk("R6 S2 = S1^2", 32'(syndromes[7:4]), 32'(mul(syndromes[3:0], syndromes[3:0])));
            if (VEC[v][14:0] == 15'h0)
                chk("R7 codeword gives zero", 32'({err_detected, syndromes}), 0);
            @(negedge clk);
            chk("R4 done one cycle", 32'(done), 0);
        end

        // R3 stalls between words
        word = encode(7'h49) ^ 15'h0100;
        send_frame(word, 1'b1);
        chk("R3 stalled frame", 32'(syndromes), 32'(expect_syn(word)));
        chk("R3 stalled done", 32'(done), 1);

        // R9 restart mid-frame
        @(negedge clk);
        data_valid = 1'b1; frame_start = 1'b1; data_word = 4'h7;
        @(negedge clk);
        frame_start = 1'b0; data_word = 4'hA;
        @(negedge clk);
        data_valid = 1'b0;
        chk("R9 no done on partial", 32'(done), 0);
        word = encode(7'h55) ^ 15'h0022;
        send_frame(word, 1'b0);
        chk("R9 restart result", 32'(syndromes), 32'(expect_syn(word)));
        chk("R9 restart done", 32'(done), 1);

        // R10 idle words ignored
        held = syndromes;
        @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            data_valid = 1'b1; frame_start = 1'b0; data_word = 4'(k + 3);
            @(negedge clk);
            chk("R10 no done from idle words", 32'(done), 0);
        end
        data_valid = 1'b0;
        @(negedge clk);
        chk("R10 syndromes unchanged", 32'(syndromes), 32'(held));
        chk("R8 err held", 32'(err_detected), 32'(held != 0));

        // R2 bit order: single error at top degree vs bottom degree
        send_frame(15'h4000, 1'b0);
        chk("R2 top-degree bit S1", 32'(syndromes[3:0]), 32'(ap[14]));
        send_frame(15'h0001, 1'b0);
        chk("R2 degree-0 bit S1", 32'(syndromes[3:0]), 32'(ap[0]));

        finish_report();
    end
endmodule